// File: doc/BRIEF.md
# TLB Entry Programming Interface

This block is the software-facing side of a set-associative translation buffer. It is a banked file of special registers. Four banks are reachable, and two of them are wired to translation arrays. Software writes a selector register in an MMU bank to point at one set and one way index. It then stages the upper word of an entry, and writing the lower word commits the pair into the array that belongs to that bank.

Reading any register of an MMU bank first copies the selected entry back into that bank's high and low registers, so a read returns the current array contents. When a commit replaces an entry whose valid bit was set, the block emits a single-cycle page-flush request. The request carries the page address of the entry that was displaced, so cached translations for that page can be dropped. The lookup path and fault handling sit elsewhere.

Top module: `tlb_prog_if`

## Requirements
- R1: The bank is taken from bits [1:0] of the bank word, and higher bits are ignored. Banks 0 and 3 are plain 16-entry register files: a write stores the value, a later read returns it, and no flush is raised.
- R2: In banks 1 and 2, register 4 is the selector. Bits [5:4] pick the set (0..3), bits [3:0] pick the index (0..15), and higher bits are ignored.
- R3: A write to register 6 of an MMU bank stores the value in both register 6 (entry high) and register 7 (cause).
- R4: A write to register 5 of an MMU bank stores the value in register 5. In the same edge it commits the entry at the selected slot of array (bank-1), with the low word equal to the written value and the high word equal to that bank's register 7.
- R5: If the entry being replaced had low-word bit 3 set, flush_o is high for the cycle after the write edge. flush_addr_o then equals the old high word with bits [12:0] cleared.
- R6: Replacing an entry whose low-word bit 3 is clear raises no flush.
- R7: A read in an MMU bank loads registers 5 and 6 from the selected entry's low and high words. The read returns the refreshed value for those registers. rd_data_o is valid one cycle after rd_en_i and holds until the next read.
- R8: The arrays behind banks 1 and 2 are independent: a commit in one is not visible through the other.
- R9: After reset, every register is zero, every entry is zero (invalid), flush_o is low and rd_data_o is zero.
- R10: When a read and a write are issued in the same cycle, the read returns the state before that edge. A write to register 5 or 6 takes priority over the refresh of the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_bank_i | input | 32 | Bank word for the write; bits [1:0] are used |
| wr_reg_i | input | 4 | Register number for the write |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_bank_i | input | 32 | Bank word for the read; bits [1:0] are used |
| rd_reg_i | input | 4 | Register number for the read |
| rd_data_o | output | 32 | Read data, one cycle after the strobe |
| flush_o | output | 1 | One-cycle page-flush request |
| flush_addr_o | output | 32 | Page address of the displaced valid entry |

## Verification
The bench focuses on commits over valid and invalid entries. A design that took the valid bit from the wrong field, or that used the new entry instead of the old one, would flush on the wrong commits or report the new page address. It also checks that the high word committed comes from the cause register, so a block that used the plain high register would differ after a direct cause write. Reads while the selector moves, same-cycle read and write, and bank words with upper bits set are all covered. These expose a refresh that lags by one cycle, a write that loses to the refresh, and decoding of more than two bank bits.

// File: rtl/tlbif_pkg.sv
package tlbif_pkg;
  localparam int REG_SEL   = 4;
  localparam int REG_LO    = 5;
  localparam int REG_HI    = 6;
  localparam int REG_CAUSE = 7;
endpackage

// File: rtl/tlbif_regbank.sv
module tlbif_regbank #(
  parameter int DATA_W    = 32,
  parameter int NREG      = 16,
  parameter bit MMU       = 1'b0,
  parameter int SEL_REG   = 4,
  parameter int LO_REG    = 5,
  parameter int HI_REG    = 6,
  parameter int CAUSE_REG = 7,
  localparam int REG_W    = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              refresh_i,
  input  logic [DATA_W-1:0] ref_hi_i,
  input  logic [DATA_W-1:0] ref_lo_i,
  input  logic [REG_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] sel_o,
  output logic [DATA_W-1:0] cause_o
);
  logic [DATA_W-1:0] regs_q [NREG];
  logic hi_wr;

  assign hi_wr = MMU && we_i && (waddr_i == REG_W'(HI_REG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      // refresh first so a same-cycle write wins
      if (MMU && refresh_i) begin
        regs_q[LO_REG] <= ref_lo_i;
        regs_q[HI_REG] <= ref_hi_i;
      end
      if (we_i) regs_q[waddr_i] <= wdata_i;
      if (hi_wr) regs_q[CAUSE_REG] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[raddr_i];
  assign sel_o   = regs_q[SEL_REG];
  assign cause_o = regs_q[CAUSE_REG];

  // R3
  cause_follows_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_wr |=> (regs_q[CAUSE_REG] == regs_q[HI_REG]));
endmodule

// File: rtl/tlbif_entry_store.sv
module tlbif_entry_store #(
  parameter int DATA_W  = 32,
  parameter int ARR_W   = 1,
  parameter int SLOT_W  = 6,
  localparam int ADDR_W = ARR_W + SLOT_W,
  localparam int NENT   = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ARR_W-1:0]  wr_arr_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [DATA_W-1:0] wr_hi_i,
  input  logic [DATA_W-1:0] wr_lo_i,
  output logic [DATA_W-1:0] wold_hi_o,
  output logic [DATA_W-1:0] wold_lo_o,
  input  logic [ARR_W-1:0]  rd_arr_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [DATA_W-1:0] rd_hi_o,
  output logic [DATA_W-1:0] rd_lo_o
);
  logic [DATA_W-1:0] hi_q [NENT];
  logic [DATA_W-1:0] lo_q [NENT];
  logic [ADDR_W-1:0] waddr, raddr;

  assign waddr = {wr_arr_i, wr_slot_i};
  assign raddr = {rd_arr_i, rd_slot_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NENT; i++) begin
        hi_q[i] <= '0;
        lo_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      hi_q[waddr] <= wr_hi_i;
      lo_q[waddr] <= wr_lo_i;
    end
  end

  assign wold_hi_o = hi_q[waddr];
  assign wold_lo_o = lo_q[waddr];
  assign rd_hi_o   = hi_q[raddr];
  assign rd_lo_o   = lo_q[raddr];
endmodule

// File: rtl/tlb_prog_if.sv
module tlb_prog_if import tlbif_pkg::*; #(
  parameter int DATA_W     = 32,
  parameter int NREG       = 16,
  parameter int NSET       = 4,
  parameter int NIDX       = 16,
  parameter int PAGE_SHIFT = 13,
  parameter int VALID_BIT  = 3,
  parameter int BANK_W     = 2,
  parameter int MMU_FIRST  = 1,
  parameter int NARR       = 2,
  localparam int REG_W     = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_bank_i,
  input  logic [REG_W-1:0]  wr_reg_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] rd_bank_i,
  input  logic [REG_W-1:0]  rd_reg_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              flush_o,
  output logic [DATA_W-1:0] flush_addr_o
);
  localparam int NBANK  = 1 << BANK_W;
  localparam int SET_W  = $clog2(NSET);
  localparam int IDX_W  = $clog2(NIDX);
  localparam int SLOT_W = SET_W + IDX_W;
  localparam int ARR_W  = (NARR > 1) ? $clog2(NARR) : 1;

  function automatic logic is_mmu(input logic [BANK_W-1:0] b);
    return (int'(b) >= MMU_FIRST) && (int'(b) < MMU_FIRST + NARR);
  endfunction

  function automatic logic [ARR_W-1:0] arr_of(input logic [BANK_W-1:0] b);
    int t;
    t = int'(b) - MMU_FIRST;
    return t[ARR_W-1:0];
  endfunction

  logic [BANK_W-1:0] wb, rb;
  logic [DATA_W-1:0] sel_w   [NBANK];
  logic [DATA_W-1:0] cause_w [NBANK];
  logic [DATA_W-1:0] rdat_w  [NBANK];
  logic [DATA_W-1:0] old_hi, old_lo, ent_hi, ent_lo;
  logic [DATA_W-1:0] wsel, rsel, rd_d;
  logic              commit, rd_mmu;

  assign wb     = wr_bank_i[BANK_W-1:0];
  assign rb     = rd_bank_i[BANK_W-1:0];
  assign wsel   = sel_w[wb];
  assign rsel   = sel_w[rb];
  assign commit = wr_en_i && is_mmu(wb) && (wr_reg_i == REG_W'(REG_LO));
  assign rd_mmu = rd_en_i && is_mmu(rb);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [BANK_W-1:0] gid;
    assign gid = BANK_W'(g);
    tlbif_regbank #(
      .DATA_W(DATA_W), .NREG(NREG),
      .MMU((g >= MMU_FIRST) && (g < MMU_FIRST + NARR)),
      .SEL_REG(REG_SEL), .LO_REG(REG_LO), .HI_REG(REG_HI), .CAUSE_REG(REG_CAUSE)
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (wr_en_i && (wb == gid)),
      .waddr_i  (wr_reg_i),
      .wdata_i  (wr_data_i),
      .refresh_i(rd_mmu && (rb == gid)),
      .ref_hi_i (ent_hi),
      .ref_lo_i (ent_lo),
      .raddr_i  (rd_reg_i),
      .rdata_o  (rdat_w[g]),
      .sel_o    (sel_w[g]),
      .cause_o  (cause_w[g])
    );
  end

  tlbif_entry_store #(.DATA_W(DATA_W), .ARR_W(ARR_W), .SLOT_W(SLOT_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (commit),
    .wr_arr_i (arr_of(wb)),
    .wr_slot_i(wsel[SLOT_W-1:0]),
    .wr_hi_i  (cause_w[wb]),
    .wr_lo_i  (wr_data_i),
    .wold_hi_o(old_hi),
    .wold_lo_o(old_lo),
    .rd_arr_i (arr_of(rb)),
    .rd_slot_i(rsel[SLOT_W-1:0]),
    .rd_hi_o  (ent_hi),
    .rd_lo_o  (ent_lo)
  );

  always_comb begin
    rd_d = rdat_w[rb];
    if (rd_mmu && rd_reg_i == REG_W'(REG_LO)) rd_d = ent_lo;
    if (rd_mmu && rd_reg_i == REG_W'(REG_HI)) rd_d = ent_hi;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o    <= '0;
      flush_o      <= 1'b0;
      flush_addr_o <= '0;
    end else begin
      if (rd_en_i) rd_data_o <= rd_d;
      flush_o <= commit && old_lo[VALID_BIT];
      if (commit && old_lo[VALID_BIT])
        flush_addr_o <= {old_hi[DATA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    end
  end

  // R1
  plain_bank_no_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !is_mmu(wb)) |=> !flush_o);
  // R5
  flush_page_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (flush_addr_o[PAGE_SHIFT-1:0] == '0));
  // R5
  flush_needs_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(commit));
  // R6
  invalid_old_no_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !old_lo[VALID_BIT]) |=> !flush_o);
endmodule

// File: tb/tlb_prog_if_tb.sv
module tlb_prog_if_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_bank = '0, rd_bank = '0, wr_data = '0;
  logic [3:0]  wr_reg = '0, rd_reg = '0;
  logic [31:0] rd_data, flush_addr;
  logic        flush;

  int total = 0, fails = 0;

  logic [31:0] m_reg [4][16];
  logic [31:0] m_hi  [2][64];
  logic [31:0] m_lo  [2][64];
  logic [31:0] exp_rd = '0;

  always #10 clk = ~clk;

  tlb_prog_if u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_bank_i(wr_bank), .wr_reg_i(wr_reg), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_bank_i(rd_bank), .rd_reg_i(rd_reg), .rd_data_o(rd_data),
    .flush_o(flush), .flush_addr_o(flush_addr)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  function automatic bit mmu(input int b);
    return b == 1 || b == 2;
  endfunction

  task automatic step(input bit we, input logic [31:0] wbw, input int wr, input logic [31:0] wd,
                      input bit re, input logic [31:0] rbw, input int rr, input string tag);
    int b, r, a, s, ra, rs;
    bit exp_fl;
    logic [31:0] exp_addr;
    b = int'(wbw[1:0]);
    r = int'(rbw[1:0]);
    exp_fl = 1'b0;
    exp_addr = '0;
    if (we && mmu(b) && wr == 5) begin
      a = b - 1;
      s = int'(m_reg[b][4][5:0]);
      if (m_lo[a][s][3]) begin
        exp_fl = 1'b1;
        exp_addr = m_hi[a][s] & 32'hFFFF_E000;
      end
    end
    if (re) begin
      exp_rd = m_reg[r][rr];
      if (mmu(r)) begin
        ra = r - 1;
        rs = int'(m_reg[r][4][5:0]);
        if (rr == 5) exp_rd = m_lo[ra][rs];
        if (rr == 6) exp_rd = m_hi[ra][rs];
      end
    end
    // next state: refresh, then write
    if (re && mmu(r)) begin
      ra = r - 1;
      rs = int'(m_reg[r][4][5:0]);
      m_reg[r][5] = m_lo[ra][rs];
      m_reg[r][6] = m_hi[ra][rs];
    end
    if (we) begin
      if (mmu(b) && wr == 5) begin
        a = b - 1;
        s = int'(m_reg[b][4][5:0]);
        m_hi[a][s] = m_reg[b][7];
        m_lo[a][s] = wd;
      end
      m_reg[b][wr] = wd;
      if (mmu(b) && wr == 6) m_reg[b][7] = wd;
    end
    wr_en = we; wr_bank = wbw; wr_reg = 4'(wr); wr_data = wd;
    rd_en = re; rd_bank = rbw; rd_reg = 4'(rr);
    @(posedge clk);
    @(negedge clk);
    chk(rd_data == exp_rd, tag, "rd_data", rd_data, exp_rd);
    chk(flush == exp_fl, tag, "flush", {31'b0, flush}, {31'b0, exp_fl});
    if (exp_fl) chk(flush_addr == exp_addr, tag, "flush_addr", flush_addr, exp_addr);
  endtask

  task automatic wr(input logic [31:0] bw, input int rg, input logic [31:0] d, input string tag);
    step(1'b1, bw, rg, d, 1'b0, 32'h0, 0, tag);
  endtask

  task automatic rd(input logic [31:0] bw, input int rg, input string tag);
    step(1'b0, 32'h0, 0, 32'h0, 1'b1, bw, rg, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) for (int j = 0; j < 16; j++) m_reg[i][j] = '0;
    for (int i = 0; i < 2; i++) for (int j = 0; j < 64; j++) begin
      m_hi[i][j] = '0;
      m_lo[i][j] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(rd_data == 32'h0, "R9", "rd_data", rd_data, 32'h0);
    chk(flush == 1'b0, "R9", "flush", {31'b0, flush}, 32'h0);
    rd(32'h1, 5, "R9");
    rd(32'h2, 7, "R9");
    // R1 plain banks, upper bank bits ignored
    wr(32'hFFFF_FF00, 3, 32'hDEAD_BEEF, "R1");
    rd(32'h0000_0000, 3, "R1");
    wr(32'h0000_0013, 5, 32'h0000_0008, "R1");
    rd(32'h3, 5, "R1");
    rd(32'h7, 6, "R1");
    // R2 R3 R4 commit into bank 1 slot set2/idx7
    wr(32'h1, 4, 32'h0000_0027, "R2");
    wr(32'h1, 6, 32'h1234_6008, "R3");
    rd(32'h1, 7, "R3");
    wr(32'h1, 5, 32'h0000_0008, "R6");
    wr(32'h1, 4, 32'h0000_0011, "R2");
    rd(32'h1, 5, "R7");
    wr(32'h1, 4, 32'hFFFF_FF27, "R2");
    rd(32'h1, 5, "R7");
    rd(32'h1, 6, "R4");
    // R4 high word comes from cause, not from register 6
    wr(32'h1, 4, 32'h0000_0003, "R2");
    wr(32'h1, 6, 32'h5555_0000, "R4");
    wr(32'h1, 7, 32'h7777_2000, "R4");
    wr(32'h1, 5, 32'h0000_0009, "R4");
    rd(32'h1, 6, "R4");
    // R5 overwrite valid entry
    wr(32'h1, 4, 32'h0000_0027, "R2");
    wr(32'h1, 6, 32'hABCD_0000, "R5");
    wr(32'h1, 5, 32'h0000_0001, "R5");
    wr(32'h1, 5, 32'h0000_0008, "R6");
    wr(32'h1, 5, 32'h0000_0000, "R5");
    // R8 bank 2 independent
    wr(32'h2, 4, 32'h0000_0027, "R8");
    rd(32'h2, 5, "R8");
    rd(32'h2, 6, "R8");
    // R10 same-cycle read and write
    step(1'b1, 32'h1, 6, 32'h0F0F_0F0F, 1'b1, 32'h1, 6, "R10");
    rd(32'h1, 6, "R10");
    step(1'b1, 32'h2, 5, 32'h0000_1008, 1'b1, 32'h2, 5, "R10");
    rd(32'h2, 5, "R10");
    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      logic [31:0] d;
      int rgw;
      rgw = ($urandom % 4 == 0) ? int'($urandom % 16) : 4 + int'($urandom % 4);
      d = $urandom;
      if (rgw == 4) d = d & 32'hFFFF_FF03;
      step($urandom % 3 != 0, $urandom, rgw, d,
           $urandom % 2 == 0, $urandom, int'($urandom % 8), "R7");
    end
    finish_run();
  end
endmodule